// File: doc/BRIEF.md
# Indirect Register Access Window

This block is the host-facing register window of a network controller. A host access hits the window when its address falls inside a 32-byte block. That block sits either at an I/O base or at a memory base, and each base has its own enable. The window holds the following:

- a 16-byte station-address PROM area, filled through a parallel byte preload port;
- a pointer register that selects an internal register index;
- a data port for the control/status bank;
- a data port for the bus-control bank;
- a soft-reset port.

Both data ports act on the entry that the one shared pointer selects.

After a hard reset the window runs in 16-bit (word) mode. In that mode the ports sit at 16-bit offsets. A single 32-bit write to the control/status data port moves the window into 32-bit (doubleword) mode. In doubleword mode every port is 32 bits wide at 4-byte spacing, and only a hard reset returns the window to word mode. Reading the soft-reset port issues a one-cycle soft-reset pulse, which clears the pointer. The control/status bank, the bus-control bank and the access mode keep their contents across the pulse.

Each host access gets a registered response one cycle later. The response carries a hit flag and the read data.

Top module: `nic_regwin`

## Requirements
- R1: An access is serviced only if `acc_addr[31:5]` equals the enabled base (`io_base` with `io_en` when `acc_mem`=0, `mem_base` with `mem_en` when `acc_mem`=1). Otherwise `resp_hit`=0, `resp_rdata`=0 and no state changes.
- R2: The I/O and memory decodes work at the same time and reach the same registers.
- R3: A write to the pointer port stores `acc_wdata[RAP_W-1:0]`. The pointer keeps this value until it is written again, a soft reset occurs, or a hard reset occurs. A read of the pointer port returns the value zero-extended.
- R4: The control/status data port reads and writes control/status entry [pointer]. A word access carries bits 15:0 and stores the upper half as zero.
- R5: The bus-control data port reads and writes bus-control entry [pointer]. The two banks are separate storage.
- R6: If the pointer is not below a bank's entry count, reads of that bank return 0 and writes to it are dropped. No other entry is touched.
- R7: A read of the reset port raises `sreset_o` for the cycle after the access (together with the response) and clears the pointer. The mode and the bank contents stay unchanged. A write to the reset port has no effect.
- R8: `stop_o` mirrors bit `STOP_BIT` (default 2) of control/status entry 0. Writing that bit leaves the pointer unchanged.
- R9: After a hard reset, the word-mode map applies: PROM 0x00-0x0F, control/status data port 0x10, pointer 0x12, reset port 0x14, bus-control data port 0x16. `dword_mode_o`=0.
- R10: In word mode, a 32-bit write to offset 0x10 sets `dword_mode_o`=1 and also stores its full 32 bits in control/status entry [pointer]. The map then becomes: PROM 0x00-0x0F, control/status data port 0x10, pointer 0x14, reset port 0x18, bus-control data port 0x1C. Only a hard reset clears the mode.
- R11: The following accesses are not serviced (`resp_hit`=0): a width that does not match the mode (other than the switching write), a misaligned offset, or an unmapped offset.
- R12: A preload writes `pre_byte` to PROM byte `pre_idx`. A word read at offset o returns {byte o+1, byte o}. A doubleword read returns {o+3, o+2, o+1, o}. Host writes to the PROM are serviced without changing it. A hard reset clears the PROM to zero.
- R13: `resp_valid` is 1 exactly one cycle after each `acc_valid`. Write responses carry `resp_rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low |
| io_en | input | 1 | I/O space decode enable |
| mem_en | input | 1 | Memory space decode enable |
| io_base | input | ADDR_W-5 | I/O window base, in 32-byte units |
| mem_base | input | ADDR_W-5 | Memory window base, in 32-byte units |
| acc_valid | input | 1 | Host access strobe |
| acc_mem | input | 1 | 1 = memory space, 0 = I/O space |
| acc_write | input | 1 | 1 = write |
| acc_dword | input | 1 | 1 = 32-bit access, 0 = 16-bit |
| acc_addr | input | ADDR_W | Access byte address |
| acc_wdata | input | 32 | Write data |
| pre_we | input | 1 | PROM preload strobe |
| pre_idx | input | 4 | PROM preload byte index |
| pre_byte | input | 8 | PROM preload byte |
| resp_valid | output | 1 | Response strobe |
| resp_hit | output | 1 | Access was serviced |
| resp_rdata | output | 32 | Read data |
| dword_mode_o | output | 1 | Doubleword mode active |
| sreset_o | output | 1 | Soft-reset pulse |
| stop_o | output | 1 | Stop control bit |

## Verification
The bench builds the block with 16 control/status entries, 8 bus-control entries and an 8-bit pointer. With these sizes, pointer values past either bank are easy to write. Index 20 lies past the 16-entry bank and wraps onto index 4 if the upper pointer bits are lost, so the bench can show that a dropped write truly touches nothing. Index 15 exercises the last legal entry. With the small banks, the soft reset, the mode switch and the hard reset can all be checked against bank contents that the bench has written and tracked itself.

// File: rtl/nic_regwin_pkg.sv
package nic_regwin_pkg;

  localparam int WIN_BITS = 5;

  typedef enum logic [2:0] {
    PK_NONE,
    PK_PROM,
    PK_CDATA,
    PK_PTR,
    PK_RST,
    PK_BDATA
  } port_e;

  // True when a word-mode 32-bit write to the control/status port flips the mode
  function automatic logic f_mode_switch(input logic [4:0] off, input logic dw_acc,
                                         input logic dw_mode, input logic wr);
    return !dw_mode && dw_acc && wr && (off == 5'h10);
  endfunction

  // Map a window offset to a port for the current mode and access width
  function automatic port_e f_port(input logic [4:0] off, input logic dw_acc,
                                   input logic dw_mode, input logic wr);
    port_e p;
    p = PK_NONE;
    if (f_mode_switch(off, dw_acc, dw_mode, wr)) begin
      p = PK_CDATA;
    end else if (dw_acc == dw_mode) begin
      if (dw_mode) begin
        if (off[1:0] == 2'b00) begin
          case (off[4:2])
            3'd0, 3'd1, 3'd2, 3'd3: p = PK_PROM;
            3'd4: p = PK_CDATA;
            3'd5: p = PK_PTR;
            3'd6: p = PK_RST;
            default: p = PK_BDATA;
          endcase
        end
      end else begin
        if (off[0] == 1'b0) begin
          if (off[4] == 1'b0) begin
            p = PK_PROM;
          end else begin
            case (off[3:1])
              3'd0: p = PK_CDATA;
              3'd1: p = PK_PTR;
              3'd2: p = PK_RST;
              3'd3: p = PK_BDATA;
              default: p = PK_NONE;
            endcase
          end
        end
      end
    end
    return p;
  endfunction

  // Word writes carry only the low half
  function automatic logic [31:0] f_wr_value(input logic [31:0] wd, input logic dw_acc);
    return dw_acc ? wd : {16'h0000, wd[15:0]};
  endfunction

endpackage

// File: rtl/nic_regwin_decode.sv
module nic_regwin_decode
  import nic_regwin_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                   acc_valid,
  input  logic                   acc_mem,
  input  logic                   acc_write,
  input  logic                   acc_dword,
  input  logic [ADDR_W-1:0]      acc_addr,
  input  logic                   io_en,
  input  logic                   mem_en,
  input  logic [ADDR_W-WIN_BITS-1:0] io_base,
  input  logic [ADDR_W-WIN_BITS-1:0] mem_base,
  input  logic                   dword_mode,
  output logic                   hit,
  output port_e                  sel,
  output logic                   mode_sw,
  output logic [WIN_BITS-1:0]    off
);

  logic io_hit;
  logic mem_hit;
  port_e kind;

  assign off     = acc_addr[WIN_BITS-1:0];
  assign io_hit  = !acc_mem && io_en  && (acc_addr[ADDR_W-1:WIN_BITS] == io_base);
  assign mem_hit =  acc_mem && mem_en && (acc_addr[ADDR_W-1:WIN_BITS] == mem_base);
  assign kind    = f_port(off, acc_dword, dword_mode, acc_write);

  always_comb begin
    hit     = acc_valid && (io_hit || mem_hit) && (kind != PK_NONE);
    sel     = hit ? kind : PK_NONE;
    mode_sw = hit && f_mode_switch(off, acc_dword, dword_mode, acc_write);
  end

endmodule

// File: rtl/nic_regwin_ptr.sv
module nic_regwin_ptr #(
  parameter int RAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             we,
  input  logic [RAP_W-1:0] wdata,
  output logic [RAP_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (clr) begin
      q <= '0;
    end else if (we) begin
      q <= wdata;
    end
  end

endmodule

// File: rtl/nic_regwin_bank.sv
module nic_regwin_bank #(
  parameter int N        = 128,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 8,
  parameter int FLAG_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              flag0
);

  localparam int IW = $clog2(N);

  logic [DATA_W-1:0] ent [N];
  logic              in_range;
  logic [IW-1:0]     slot;

  assign in_range = (int'(idx) < N);
  assign slot     = idx[IW-1:0];
  assign rdata    = in_range ? ent[slot] : '0;
  assign flag0    = ent[0][FLAG_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        ent[i] <= '0;
      end
    end else if (we && in_range) begin
      ent[slot] <= wdata;
    end
  end

endmodule

// File: rtl/nic_regwin_prom.sv
module nic_regwin_prom #(
  parameter int BYTES = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pre_we,
  input  logic [$clog2(BYTES)-1:0] pre_idx,
  input  logic [7:0]               pre_byte,
  input  logic [$clog2(BYTES)-1:0] off,
  input  logic                     dw,
  output logic [31:0]              rdata
);

  localparam int AW = $clog2(BYTES);

  logic [7:0]    mem [BYTES];
  logic [AW-1:0] base;

  assign base = dw ? {off[AW-1:2], 2'b00} : {off[AW-1:1], 1'b0};

  always_comb begin
    rdata = '0;
    for (int k = 0; k < 4; k++) begin
      if (dw || k < 2) begin
        rdata[8*k +: 8] = mem[base + AW'(k)];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BYTES; i++) begin
        mem[i] <= '0;
      end
    end else if (pre_we) begin
      mem[pre_idx] <= pre_byte;
    end
  end

endmodule

// File: rtl/nic_regwin.sv
module nic_regwin
  import nic_regwin_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CSR_N    = 128,
  parameter int BCR_N    = 64,
  parameter int RAP_W    = 8,
  parameter int STOP_BIT = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       io_en,
  input  logic                       mem_en,
  input  logic [ADDR_W-WIN_BITS-1:0] io_base,
  input  logic [ADDR_W-WIN_BITS-1:0] mem_base,
  input  logic                       acc_valid,
  input  logic                       acc_mem,
  input  logic                       acc_write,
  input  logic                       acc_dword,
  input  logic [ADDR_W-1:0]          acc_addr,
  input  logic [31:0]                acc_wdata,
  input  logic                       pre_we,
  input  logic [3:0]                 pre_idx,
  input  logic [7:0]                 pre_byte,
  output logic                       resp_valid,
  output logic                       resp_hit,
  output logic [31:0]                resp_rdata,
  output logic                       dword_mode_o,
  output logic                       sreset_o,
  output logic                       stop_o
);

  localparam int PROM_BYTES = 16;

  // Named internal events, observed by the bound checker
  logic             win_hit_ev;
  logic             rap_wr_ev;
  logic             srst_ev;
  logic             mode_sw_ev;
  logic             csr_wr_ev;
  logic             bcr_wr_ev;
  logic [RAP_W-1:0] rap_q;

  port_e               sel;
  logic [WIN_BITS-1:0] off;
  logic [31:0]         wr_val;
  logic [31:0]         csr_rd;
  logic [31:0]         bcr_rd;
  logic [31:0]         prom_rd;
  logic [31:0]         rd_mux;
  logic                dword_q;
  logic                csr_flag;
  logic                bcr_flag;

  nic_regwin_decode #(.ADDR_W(ADDR_W)) u_dec (
    .acc_valid (acc_valid),
    .acc_mem   (acc_mem),
    .acc_write (acc_write),
    .acc_dword (acc_dword),
    .acc_addr  (acc_addr),
    .io_en     (io_en),
    .mem_en    (mem_en),
    .io_base   (io_base),
    .mem_base  (mem_base),
    .dword_mode(dword_q),
    .hit       (win_hit_ev),
    .sel       (sel),
    .mode_sw   (mode_sw_ev),
    .off       (off)
  );

  assign wr_val    = f_wr_value(acc_wdata, acc_dword);
  assign rap_wr_ev = win_hit_ev && acc_write  && (sel == PK_PTR);
  assign srst_ev   = win_hit_ev && !acc_write && (sel == PK_RST);
  assign csr_wr_ev = win_hit_ev && acc_write  && (sel == PK_CDATA);
  assign bcr_wr_ev = win_hit_ev && acc_write  && (sel == PK_BDATA);

  nic_regwin_ptr #(.RAP_W(RAP_W)) u_ptr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (srst_ev),
    .we   (rap_wr_ev),
    .wdata(acc_wdata[RAP_W-1:0]),
    .q    (rap_q)
  );

  nic_regwin_bank #(.N(CSR_N), .DATA_W(32), .IDX_W(RAP_W), .FLAG_BIT(STOP_BIT)) u_csr (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (csr_wr_ev),
    .idx  (rap_q),
    .wdata(wr_val),
    .rdata(csr_rd),
    .flag0(csr_flag)
  );

  nic_regwin_bank #(.N(BCR_N), .DATA_W(32), .IDX_W(RAP_W), .FLAG_BIT(0)) u_bcr (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (bcr_wr_ev),
    .idx  (rap_q),
    .wdata(wr_val),
    .rdata(bcr_rd),
    .flag0(bcr_flag)
  );

  nic_regwin_prom #(.BYTES(PROM_BYTES)) u_prom (
    .clk     (clk),
    .rst_n   (rst_n),
    .pre_we  (pre_we),
    .pre_idx (pre_idx),
    .pre_byte(pre_byte),
    .off     (off[3:0]),
    .dw      (dword_q),
    .rdata   (prom_rd)
  );

  always_comb begin
    rd_mux = '0;
    if (!acc_write) begin
      case (sel)
        PK_PROM:  rd_mux = prom_rd;
        PK_CDATA: rd_mux = csr_rd;
        PK_PTR:   rd_mux = 32'(rap_q);
        PK_BDATA: rd_mux = bcr_rd;
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dword_q    <= 1'b0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_rdata <= '0;
      sreset_o   <= 1'b0;
    end else begin
      if (mode_sw_ev) begin
        dword_q <= 1'b1;
      end
      resp_valid <= acc_valid;
      resp_hit   <= win_hit_ev;
      resp_rdata <= rd_mux;
      sreset_o   <= srst_ev;
    end
  end

  assign dword_mode_o = dword_q;
  assign stop_o       = csr_flag;

  logic unused_ok;
  assign unused_ok = bcr_flag;

endmodule

// File: rtl/nic_regwin_chk.sv
module nic_regwin_chk #(
  parameter int RAP_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             acc_valid,
  input logic             resp_valid,
  input logic             resp_hit,
  input logic [31:0]      resp_rdata,
  input logic             sreset_o,
  input logic             stop_o,
  input logic             dword_mode_o,
  input logic [RAP_W-1:0] rap_q,
  input logic             rap_wr_ev,
  input logic             srst_ev
);

  AST_MISS_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_hit) |-> (resp_rdata == '0));  // R1

  AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rap_wr_ev && !srst_ev) |=> $stable(rap_q));  // R3

  AST_SRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    srst_ev |=> sreset_o);  // R7

  AST_SRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !srst_ev |=> !sreset_o);  // R7

  AST_SRST_PTR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    sreset_o |-> (rap_q == '0));  // R7

  AST_STOP_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_o) |-> $stable(rap_q));  // R8

  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    dword_mode_o |=> dword_mode_o);  // R10

  AST_RESP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> resp_valid);  // R13

  AST_RESP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !resp_valid);  // R13

endmodule

bind nic_regwin nic_regwin_chk #(.RAP_W(RAP_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_valid   (acc_valid),
  .resp_valid  (resp_valid),
  .resp_hit    (resp_hit),
  .resp_rdata  (resp_rdata),
  .sreset_o    (sreset_o),
  .stop_o      (stop_o),
  .dword_mode_o(dword_mode_o),
  .rap_q       (rap_q),
  .rap_wr_ev   (rap_wr_ev),
  .srst_ev     (srst_ev)
);

// File: tb/sim_nic_regwin.sv
module sim_nic_regwin;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int CSR_N  = 16;
  localparam int BCR_N  = 8;
  localparam int RAP_W  = 8;
  localparam logic [ADDR_W-1:0] IO_ADDR  = 32'h0000_0300;
  localparam logic [ADDR_W-1:0] MEM_ADDR = 32'hFEDC_0040;

  // vector: tag(4) mem wr dw off(5) wdata(32) exp_hit exp_rdata(32)
  localparam int NV = 24;
  localparam logic [76:0] VECS [NV] = '{
    {4'd3,  1'b0, 1'b1, 1'b0, 5'h12, 32'h0000_0003, 1'b1, 32'h0},           // R3 set ptr 3
    {4'd3,  1'b0, 1'b0, 1'b0, 5'h12, 32'h0,         1'b1, 32'h0000_0003},   // R3 read ptr
    {4'd4,  1'b0, 1'b1, 1'b0, 5'h10, 32'h0000_BEEF, 1'b1, 32'h0},           // R4 write csr3
    {4'd4,  1'b0, 1'b0, 1'b0, 5'h10, 32'h0,         1'b1, 32'h0000_BEEF},   // R4 read csr3
    {4'd2,  1'b1, 1'b1, 1'b0, 5'h12, 32'h0000_0005, 1'b1, 32'h0},           // R2 ptr via memory
    {4'd5,  1'b1, 1'b1, 1'b0, 5'h16, 32'h0000_1234, 1'b1, 32'h0},           // R5 write bcr5
    {4'd5,  1'b0, 1'b0, 1'b0, 5'h16, 32'h0,         1'b1, 32'h0000_1234},   // R5 read via I/O
    {4'd5,  1'b0, 1'b0, 1'b0, 5'h10, 32'h0,         1'b1, 32'h0},           // R5 csr5 separate
    {4'd3,  1'b0, 1'b1, 1'b0, 5'h12, 32'h0000_0003, 1'b1, 32'h0},           // R3
    {4'd4,  1'b0, 1'b1, 1'b0, 5'h10, 32'hFFFF_A5A5, 1'b1, 32'h0},           // R4 word write
    {4'd4,  1'b0, 1'b0, 1'b0, 5'h10, 32'h0,         1'b1, 32'h0000_A5A5},   // R4 upper zero
    {4'd6,  1'b0, 1'b1, 1'b0, 5'h12, 32'h0000_0014, 1'b1, 32'h0},           // R6 ptr 20
    {4'd6,  1'b0, 1'b1, 1'b0, 5'h10, 32'h0000_1111, 1'b1, 32'h0},           // R6 dropped write
    {4'd6,  1'b0, 1'b0, 1'b0, 5'h10, 32'h0,         1'b1, 32'h0},           // R6 read 0
    {4'd6,  1'b0, 1'b0, 1'b0, 5'h16, 32'h0,         1'b1, 32'h0},           // R6 bcr range
    {4'd11, 1'b0, 1'b0, 1'b0, 5'h1E, 32'h0,         1'b0, 32'h0},           // R11 unmapped
    {4'd11, 1'b0, 1'b0, 1'b1, 5'h12, 32'h0,         1'b0, 32'h0},           // R11 width
    {4'd11, 1'b0, 1'b0, 1'b0, 5'h13, 32'h0,         1'b0, 32'h0},           // R11 misaligned
    {4'd3,  1'b0, 1'b0, 1'b0, 5'h12, 32'h0,         1'b1, 32'h0000_0014},   // R3 still 20
    {4'd6,  1'b0, 1'b1, 1'b0, 5'h12, 32'h0000_000F, 1'b1, 32'h0},           // R6 last entry
    {4'd6,  1'b0, 1'b1, 1'b0, 5'h10, 32'h0000_7777, 1'b1, 32'h0},
    {4'd6,  1'b0, 1'b0, 1'b0, 5'h10, 32'h0,         1'b1, 32'h0000_7777},
    {4'd6,  1'b0, 1'b1, 1'b0, 5'h12, 32'h0000_0004, 1'b1, 32'h0},           // R6 no wrap to 4
    {4'd6,  1'b0, 1'b0, 1'b0, 5'h10, 32'h0,         1'b1, 32'h0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_en = 1'b1;
  logic mem_en = 1'b1;
  logic acc_valid = 1'b0;
  logic acc_mem = 1'b0;
  logic acc_write = 1'b0;
  logic acc_dword = 1'b0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic [31:0] acc_wdata = '0;
  logic pre_we = 1'b0;
  logic [3:0] pre_idx = '0;
  logic [7:0] pre_byte = '0;
  logic resp_valid, resp_hit, dword_mode_o, sreset_o, stop_o;
  logic [31:0] resp_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic r_valid, r_hit, r_srst;
  logic [31:0] r_data;

  nic_regwin #(.ADDR_W(ADDR_W), .CSR_N(CSR_N), .BCR_N(BCR_N), .RAP_W(RAP_W), .STOP_BIT(2)) u0 (
    .clk(clk), .rst_n(rst_n), .io_en(io_en), .mem_en(mem_en),
    .io_base(IO_ADDR[ADDR_W-1:5]), .mem_base(MEM_ADDR[ADDR_W-1:5]),
    .acc_valid(acc_valid), .acc_mem(acc_mem), .acc_write(acc_write), .acc_dword(acc_dword),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .pre_we(pre_we), .pre_idx(pre_idx), .pre_byte(pre_byte),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
    .dword_mode_o(dword_mode_o), .sreset_o(sreset_o), .stop_o(stop_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one access at a falling edge; capture the response one edge later
  task automatic acc_raw(input logic [ADDR_W-1:0] addr, input logic mem, input logic wr,
                         input logic dw, input logic [31:0] wd);
    acc_valid = 1'b1; acc_mem = mem; acc_write = wr; acc_dword = dw;
    acc_addr = addr; acc_wdata = wd;
    @(negedge clk);
    r_valid = resp_valid; r_hit = resp_hit; r_data = resp_rdata; r_srst = sreset_o;
    acc_valid = 1'b0;
  endtask

  task automatic acc(input logic mem, input logic wr, input logic dw,
                     input logic [4:0] off, input logic [31:0] wd);
    acc_raw((mem ? MEM_ADDR : IO_ADDR) | 32'(off), mem, wr, dw, wd);
  endtask

  task automatic expect_resp(input string tag, input logic hit, input logic [31:0] data);
    check(tag, {31'h0, r_valid, 31'h0, r_hit}, {31'h0, 1'b1, 31'h0, hit});
    check(tag, 64'(r_data), 64'(data));
  endtask

  task automatic hard_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state and word map
    check("R9 reset outputs", 64'({resp_valid, dword_mode_o, sreset_o, stop_o}), 64'd0);
    acc(1'b0, 1'b0, 1'b0, 5'h12, 32'h0);
    expect_resp("R9 ptr after reset", 1'b1, 32'h0);
    @(negedge clk);
    check("R13 idle no response", 64'(resp_valid), 64'd0);

    // R12 PROM preload and reads
    for (int i = 0; i < 16; i++) begin
      pre_we = 1'b1; pre_idx = 4'(i); pre_byte = 8'hA0 + 8'(i);
      @(negedge clk);
    end
    pre_we = 1'b0;
    acc(1'b0, 1'b0, 1'b0, 5'h04, 32'h0);
    expect_resp("R12 word read", 1'b1, 32'h0000_A5A4);
    acc(1'b0, 1'b1, 1'b0, 5'h02, 32'h0000_5555);
    expect_resp("R13 write data zero", 1'b1, 32'h0);
    acc(1'b1, 1'b0, 1'b0, 5'h02, 32'h0);
    expect_resp("R12 host write ignored", 1'b1, 32'h0000_A3A2);

    // Table of vectors (R2 R3 R4 R5 R6 R11)
    for (int i = 0; i < NV; i++) begin
      logic [76:0] v;
      v = VECS[i];
      acc(v[72], v[71], v[70], v[69:65], v[64:33]);
      expect_resp($sformatf("R%0d vector %0d", v[76:73], i), v[32], v[31:0]);
    end

    // R1 enables and base decode
    io_en = 1'b0;
    acc(1'b0, 1'b0, 1'b0, 5'h12, 32'h0);
    expect_resp("R1 io disabled", 1'b0, 32'h0);
    acc(1'b1, 1'b0, 1'b0, 5'h12, 32'h0);
    expect_resp("R2 memory while io off", 1'b1, 32'h4);
    io_en = 1'b1; mem_en = 1'b0;
    acc(1'b1, 1'b1, 1'b0, 5'h12, 32'h9);
    expect_resp("R1 mem disabled", 1'b0, 32'h0);
    mem_en = 1'b1;
    acc_raw(IO_ADDR + 32'h20 + 32'h12, 1'b0, 1'b1, 1'b0, 32'h9);
    expect_resp("R1 outside window", 1'b0, 32'h0);
    acc(1'b0, 1'b0, 1'b0, 5'h12, 32'h0);
    expect_resp("R1 ptr untouched by miss", 1'b1, 32'h4);

    // R8 stop bit
    acc(1'b0, 1'b1, 1'b0, 5'h12, 32'h0);
    acc(1'b0, 1'b1, 1'b0, 5'h10, 32'h0000_0004);
    check("R8 stop set", 64'(stop_o), 64'd1);
    acc(1'b0, 1'b0, 1'b0, 5'h12, 32'h0);
    expect_resp("R8 ptr unchanged", 1'b1, 32'h0);

    // R7 soft reset port
    acc(1'b0, 1'b1, 1'b0, 5'h12, 32'h3);
    acc(1'b0, 1'b1, 1'b0, 5'h14, 32'hFFFF);
    check("R7 write no pulse", 64'(r_srst), 64'd0);
    acc(1'b0, 1'b0, 1'b0, 5'h12, 32'h0);
    expect_resp("R7 write keeps ptr", 1'b1, 32'h3);
    acc(1'b0, 1'b0, 1'b0, 5'h14, 32'h0);
    check("R7 pulse", 64'(r_srst), 64'd1);
    @(negedge clk);
    check("R7 pulse one cycle", 64'(sreset_o), 64'd0);
    acc(1'b0, 1'b0, 1'b0, 5'h12, 32'h0);
    expect_resp("R7 ptr cleared", 1'b1, 32'h0);
    acc(1'b0, 1'b1, 1'b0, 5'h12, 32'h3);
    acc(1'b0, 1'b0, 1'b0, 5'h10, 32'h0);
    expect_resp("R7 csr kept", 1'b1, 32'h0000_A5A5);

    // R10 mode switch
    acc(1'b0, 1'b1, 1'b0, 5'h12, 32'h2);
    acc(1'b0, 1'b1, 1'b1, 5'h10, 32'hCAFE_1357);
    check("R10 mode set", 64'(dword_mode_o), 64'd1);
    acc(1'b0, 1'b0, 1'b1, 5'h10, 32'h0);
    expect_resp("R10 full write stored", 1'b1, 32'hCAFE_1357);
    acc(1'b0, 1'b1, 1'b1, 5'h14, 32'h5);
    acc(1'b1, 1'b0, 1'b1, 5'h1C, 32'h0);
    expect_resp("R10 bcr at new offset", 1'b1, 32'h0000_1234);
    acc(1'b0, 1'b0, 1'b0, 5'h12, 32'h0);
    expect_resp("R11 word in dword mode", 1'b0, 32'h0);
    acc(1'b0, 1'b0, 1'b1, 5'h04, 32'h0);
    expect_resp("R12 dword read", 1'b1, 32'hA7A6_A5A4);
    acc(1'b0, 1'b0, 1'b1, 5'h18, 32'h0);
    check("R7 dword reset port", 64'(r_srst), 64'd1);
    acc(1'b0, 1'b0, 1'b1, 5'h14, 32'h0);
    expect_resp("R10 mode survives soft reset", 1'b1, 32'h0);

    // Hard reset returns everything
    hard_reset();
    check("R9 mode cleared", 64'(dword_mode_o), 64'd0);
    acc(1'b0, 1'b0, 1'b0, 5'h00, 32'h0);
    expect_resp("R12 prom cleared", 1'b1, 32'h0);
    acc(1'b0, 1'b1, 1'b0, 5'h12, 32'h3);
    acc(1'b0, 1'b0, 1'b0, 5'h10, 32'h0);
    expect_resp("R4 csr cleared by hard reset", 1'b1, 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule